// File: doc/BRIEF.md
# Coarse-Fine Pixel Time-of-Flight Stamper

This block time-stamps photon arrivals for a small gated imaging array. Every pixel has its own 10-bit pseudo-random shift-register counter that moves forward on a reference tick. The tick comes from one of two sources, chosen by a select input: a ring-oscillator tick or an external tick. All counters load the same non-zero seed when a frame starts. When the first detection pulse of a frame reaches a pixel, that pixel freezes its counter and stores the 3-bit phase code of a delay line that all pixels share. The pixel then does nothing until the next frame start.

The detection pulses are asynchronous. Each one passes through a two-stage synchroniser and a rising-edge detector before it can cause a capture. A gate-close input ends the counting window. A host reads one pixel per request through an address port. When the returned word holds a capture, an iterative decoder turns the pseudo-random state back into a plain count of ticks since the frame started.

Top module: `tof_tdc_array`

## Requirements
- R1: After reset, every pixel reads as not captured, the gate is closed, `rd_data_vld` is 0 and `dec_busy` is 0.
- R2: A `frame_start` pulse clears every capture flag, loads every pixel counter with the seed 10'h001 and opens the gate at the same clock edge.
- R3: While the gate is open, an uncaptured pixel counter steps once at each clock edge where the selected tick is 1. `clk_sel`=0 selects `ring_tick` and `clk_sel`=1 selects `ext_tick`. The step shifts left and inserts bit9 XOR bit6 as the new bit 0, which is the polynomial x^10+x^7+1.
- R4: A pixel captures at the third rising clock edge that samples its `hit_async` line high after that line was low. The stored coarse value is the counter state before that edge, so the counter does not step at the capture edge. The stored fine value is `fine_phase` as sampled at that same edge.
- R5: After a capture, further pulses on that pixel have no effect on its stored word until the next `frame_start`.
- R6: While the gate is closed, before the first frame or after `gate_close`, detection pulses are not captured.
- R7: Pixels are independent. A pixel that receives no pulse in a frame reads with its capture flag at 0.
- R8: A read request (`rd_en` high with `rd_addr`) returns the capture flag, coarse state and fine code of that pixel at the next clock edge, with `rd_data_vld` high for one cycle.
- R9: When a returned word has its capture flag set, the decoder starts by itself. Within 1024 cycles it pulses `dec_done` with `dec_count` equal to the number of steps from the seed to the returned coarse state.
- R10: When `frame_start` and a capture strobe fall on the same edge, `frame_start` wins and the pixel stays uncaptured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Clears pixels, loads seeds, opens the gate |
| gate_close | input | 1 | Closes the counting window |
| clk_sel | input | 1 | Tick source: 0 ring, 1 external |
| ring_tick | input | 1 | Ring-oscillator tick enable |
| ext_tick | input | 1 | External tick enable |
| fine_phase | input | 3 | Shared delay-line phase code |
| hit_async | input | 64 | Asynchronous detection pulse per pixel |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Pixel index to read |
| rd_data_vld | output | 1 | Read data returned this cycle |
| rd_hit | output | 1 | Capture flag of read pixel |
| rd_coarse | output | 10 | Frozen counter state of read pixel |
| rd_fine | output | 3 | Stored fine code of read pixel |
| dec_busy | output | 1 | Decoder is searching |
| dec_done | output | 1 | One-cycle pulse: decode finished |
| dec_count | output | 10 | Decoded tick count |

## Verification
The case that matters most is a capture strobe landing on an edge where the tick is also active. The bench drives the tick continuously while a pulse arrives, and it expects the state from before that edge. A second collision, a capture strobe on the same edge as `frame_start`, is set up by timing a pulse two edges before the frame start. That pixel must then read as uncaptured. In both cases the bench judges only the read port and the decoded count, and it computes the expected values from its own model of the counter polynomial.

// File: rtl/tof_tdc_pkg.sv
package tof_tdc_pkg;

    localparam int COARSE_W = 10;
    localparam int FINE_W   = 3;
    localparam logic [COARSE_W-1:0] SEED = 10'h001;
    localparam logic [COARSE_W-1:0] TAPS = 10'h240;

    typedef struct packed {
        logic                vld;
        logic [COARSE_W-1:0] lfsr;
        logic [FINE_W-1:0]   fine;
    } pix_state_t;

    function automatic logic [COARSE_W-1:0] lfsr_next(input logic [COARSE_W-1:0] cur);
        return {cur[COARSE_W-2:0], ^(cur & TAPS)};
    endfunction

endpackage

// File: rtl/tof_hit_sync.sv
module tof_hit_sync #(
    parameter int NPIX = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] hit_async,
    output logic [NPIX-1:0] strobe
);

    typedef struct packed {
        logic [NPIX-1:0] meta;
        logic [NPIX-1:0] sync;
        logic [NPIX-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = hit_async;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.sync & ~st_q.prev;

endmodule

// File: rtl/tof_pixel.sv
module tof_pixel
    import tof_tdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                gate_open,
    input  logic                tick,
    input  logic                strobe,
    input  logic [FINE_W-1:0]   fine_phase,
    output logic                vld,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine
);

    pix_state_t px_d, px_q;

    always_comb begin
        px_d = px_q;
        if (frame_start) begin
            px_d.vld  = 1'b0;
            px_d.lfsr = SEED;
            px_d.fine = '0;
        end else if (!px_q.vld && gate_open) begin
            if (strobe) begin
                px_d.vld  = 1'b1;
                px_d.fine = fine_phase;
            end else if (tick) begin
                px_d.lfsr = lfsr_next(px_q.lfsr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q.vld  <= 1'b0;
            px_q.lfsr <= SEED;
            px_q.fine <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign vld    = px_q.vld;
    assign coarse = px_q.lfsr;
    assign fine   = px_q.fine;

endmodule

// File: rtl/tof_readout.sv
module tof_readout
    import tof_tdc_pkg::*;
#(
    parameter int NPIX = 64,
    localparam int AW  = $clog2(NPIX)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [AW-1:0]                  rd_addr,
    input  logic [NPIX-1:0]                pix_vld,
    input  logic [NPIX-1:0][COARSE_W-1:0]  pix_coarse,
    input  logic [NPIX-1:0][FINE_W-1:0]    pix_fine,
    output logic                           rd_data_vld,
    output logic                           rd_hit,
    output logic [COARSE_W-1:0]            rd_coarse,
    output logic [FINE_W-1:0]              rd_fine
);

    typedef struct packed {
        logic                dv;
        logic                hit;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d    = rd_q;
        rd_d.dv = rd_en;
        if (rd_en) begin
            rd_d.hit    = pix_vld[rd_addr];
            rd_d.coarse = pix_coarse[rd_addr];
            rd_d.fine   = pix_fine[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_vld = rd_q.dv;
    assign rd_hit      = rd_q.hit;
    assign rd_coarse   = rd_q.coarse;
    assign rd_fine     = rd_q.fine;

endmodule

// File: rtl/tof_lfsr_decoder.sv
module tof_lfsr_decoder
    import tof_tdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [COARSE_W-1:0] target,
    output logic                busy,
    output logic                done,
    output logic [COARSE_W-1:0] count
);

    localparam logic [COARSE_W-1:0] LAST_STEP = COARSE_W'((1 << COARSE_W) - 2);

    typedef enum logic {DEC_IDLE, DEC_RUN} dec_mode_e;

    typedef struct packed {
        dec_mode_e           mode;
        logic [COARSE_W-1:0] goal;
        logic [COARSE_W-1:0] cur;
        logic [COARSE_W-1:0] cnt;
        logic                done;
    } dec_t;

    dec_t dc_d, dc_q;

    always_comb begin
        dc_d      = dc_q;
        dc_d.done = 1'b0;
        case (dc_q.mode)
            DEC_IDLE: begin
                if (start) begin
                    dc_d.mode = DEC_RUN;
                    dc_d.goal = target;
                    dc_d.cur  = SEED;
                    dc_d.cnt  = '0;
                end
            end
            DEC_RUN: begin
                if (dc_q.cur == dc_q.goal || dc_q.cnt == LAST_STEP) begin
                    dc_d.mode = DEC_IDLE;
                    dc_d.done = 1'b1;
                end else begin
                    dc_d.cur = lfsr_next(dc_q.cur);
                    dc_d.cnt = dc_q.cnt + 1'b1;
                end
            end
            default: dc_d.mode = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q.mode <= DEC_IDLE;
            dc_q.goal <= '0;
            dc_q.cur  <= SEED;
            dc_q.cnt  <= '0;
            dc_q.done <= 1'b0;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign busy  = (dc_q.mode == DEC_RUN);
    assign done  = dc_q.done;
    assign count = dc_q.cnt;

endmodule

// File: rtl/tof_tdc_array.sv
module tof_tdc_array
    import tof_tdc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NPIX = ROWS * COLS,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                gate_close,
    input  logic                clk_sel,
    input  logic                ring_tick,
    input  logic                ext_tick,
    input  logic [FINE_W-1:0]   fine_phase,
    input  logic [NPIX-1:0]     hit_async,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic                rd_data_vld,
    output logic                rd_hit,
    output logic [COARSE_W-1:0] rd_coarse,
    output logic [FINE_W-1:0]   rd_fine,
    output logic                dec_busy,
    output logic                dec_done,
    output logic [COARSE_W-1:0] dec_count
);

    logic gate_d, gate_q;
    logic sel_tick;
    logic [NPIX-1:0]               strobe;
    logic [NPIX-1:0]               pix_vld;
    logic [NPIX-1:0][COARSE_W-1:0] pix_coarse;
    logic [NPIX-1:0][FINE_W-1:0]   pix_fine;

    always_comb begin
        gate_d = gate_q;
        if (frame_start)     gate_d = 1'b1;
        else if (gate_close) gate_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign sel_tick = clk_sel ? ext_tick : ring_tick;

    tof_hit_sync #(.NPIX(NPIX)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_async (hit_async),
        .strobe    (strobe)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        tof_pixel u_pix (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .gate_open   (gate_q),
            .tick        (sel_tick),
            .strobe      (strobe[p]),
            .fine_phase  (fine_phase),
            .vld         (pix_vld[p]),
            .coarse      (pix_coarse[p]),
            .fine        (pix_fine[p])
        );
    end

    tof_readout #(.NPIX(NPIX)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .pix_vld     (pix_vld),
        .pix_coarse  (pix_coarse),
        .pix_fine    (pix_fine),
        .rd_data_vld (rd_data_vld),
        .rd_hit      (rd_hit),
        .rd_coarse   (rd_coarse),
        .rd_fine     (rd_fine)
    );

    tof_lfsr_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rd_data_vld & rd_hit),
        .target (rd_coarse),
        .busy   (dec_busy),
        .done   (dec_done),
        .count  (dec_count)
    );

endmodule

// File: rtl/tof_tdc_checker.sv
module tof_tdc_checker
    import tof_tdc_pkg::*;
#(
    parameter int NPIX = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           frame_start,
    input logic                           rd_en,
    input logic                           rd_data_vld,
    input logic                           rd_hit,
    input logic                           dec_busy,
    input logic                           gate_q,
    input logic [NPIX-1:0]                pix_vld,
    input logic [NPIX-1:0][COARSE_W-1:0]  pix_coarse
);

    // R2: a frame start leaves every pixel uncaptured
    p_frame_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pix_vld == '0));

    // R8: one-cycle read latency
    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data_vld);

    // R9: the decoder only starts from a returned capture
    p_dec_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_busy) |-> $past(rd_data_vld && rd_hit));

    for (genvar p = 0; p < NPIX; p++) begin : g_chk
        // R5: a captured word stays put until the next frame start
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_vld[p] && !frame_start) |=> (pix_vld[p] && pix_coarse[p] == $past(pix_coarse[p])));

        // R6: a capture only happens with the gate open
        p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pix_vld[p]) |-> $past(gate_q));
    end

endmodule

bind tof_tdc_array tof_tdc_checker #(.NPIX(NPIX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .rd_en       (rd_en),
    .rd_data_vld (rd_data_vld),
    .rd_hit      (rd_hit),
    .dec_busy    (dec_busy),
    .gate_q      (gate_q),
    .pix_vld     (pix_vld),
    .pix_coarse  (pix_coarse)
);

// File: tb/tb_tof_tdc_array.sv
module tb_tof_tdc_array;

    localparam int NPIX = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        gate_close = 1'b0;
    logic        clk_sel = 1'b0;
    logic        ring_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [2:0]  fine_phase = '0;
    logic [63:0] hit_async = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        rd_data_vld, rd_hit, dec_busy, dec_done;
    logic [9:0]  rd_coarse, dec_count;
    logic [2:0]  rd_fine;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tof_tdc_array dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .gate_close(gate_close),
        .clk_sel(clk_sel), .ring_tick(ring_tick), .ext_tick(ext_tick),
        .fine_phase(fine_phase), .hit_async(hit_async), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data_vld(rd_data_vld), .rd_hit(rd_hit), .rd_coarse(rd_coarse), .rd_fine(rd_fine),
        .dec_busy(dec_busy), .dec_done(dec_done), .dec_count(dec_count)
    );

    // stimulus table: {pixel[13:8], pulse cycle[7:0]}
    localparam logic [13:0] VEC [8] = '{
        {6'd0,  8'd0}, {6'd1,  8'd1}, {6'd9,  8'd5}, {6'd63, 8'd12},
        {6'd20, 8'd20}, {6'd9, 8'd30}, {6'd33, 8'd40}, {6'd62, 8'd50}
    };

    function automatic logic [9:0] model_state(input int steps);
        logic [9:0] s = 10'h001;
        for (int k = 0; k < steps; k++) s = {s[8:0], s[9] ^ s[6]};
        return s;
    endfunction

    function automatic logic [2:0] fine_of(input int c);
        return 3'((c * 5 + 3) % 8);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_frame();
        frame_start = 1'b1;
        tick_cycle();
        frame_start = 1'b0;
    endtask

    // read one pixel, check flag, and for captures check coarse, fine and decode
    task automatic read_pix(input int pix, input bit exp_hit, input int exp_cnt,
                            input logic [2:0] exp_fine, input string req);
        rd_addr = 6'(pix);
        rd_en   = 1'b1;
        tick_cycle();
        rd_en   = 1'b0;
        check(rd_data_vld == 1'b1, "R8", int'(rd_data_vld), 1);
        check(rd_hit == exp_hit, req, int'(rd_hit), int'(exp_hit));
        if (exp_hit) begin
            check(rd_coarse == model_state(exp_cnt), req, int'(rd_coarse), int'(model_state(exp_cnt)));
            check(rd_fine == exp_fine, req, int'(rd_fine), int'(exp_fine));
            begin
                int w = 0;
                while (!dec_done && w < 1100) begin
                    tick_cycle();
                    w++;
                end
                check(dec_done == 1'b1, "R9", int'(dec_done), 1);
                check(dec_count == 10'(exp_cnt), "R9", int'(dec_count), exp_cnt);
            end
        end
        tick_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int first_m [NPIX];
        int ticks   [0:80];
        for (int p = 0; p < NPIX; p++) first_m[p] = -1;

        // R1: reset state
        repeat (3) tick_cycle();
        rst_n = 1'b1;
        tick_cycle();
        check(rd_data_vld == 1'b0, "R1", int'(rd_data_vld), 0);
        check(dec_busy == 1'b0, "R1", int'(dec_busy), 0);
        read_pix(0, 1'b0, 0, 3'd0, "R1");

        // R6: pulse before any frame, gate still closed
        hit_async[5] = 1'b1;
        repeat (5) tick_cycle();
        hit_async[5] = 1'b0;
        read_pix(5, 1'b0, 0, 3'd0, "R6");

        // Frame A: ring tick every cycle, table-driven pulses (R3, R4, R5, R7)
        clk_sel = 1'b0; ring_tick = 1'b1; ext_tick = 1'b0;
        repeat (4) tick_cycle();
        start_frame();
        ticks[0] = 0;
        for (int c = 0; c < 60; c++) begin
            fine_phase = fine_of(c);
            for (int v = 0; v < 8; v++) begin
                int pix = int'(VEC[v][13:8]);
                int m   = int'(VEC[v][7:0]);
                if (m == c) begin
                    hit_async[pix] = 1'b1;
                    if (first_m[pix] < 0) first_m[pix] = m;
                end
                if (m + 3 == c) hit_async[pix] = 1'b0;
            end
            ticks[c+1] = ticks[c] + ((clk_sel ? ext_tick : ring_tick) ? 1 : 0);
            tick_cycle();
        end
        gate_close = 1'b1;
        tick_cycle();
        gate_close = 1'b0;
        // R6: pulse after the gate has closed
        hit_async[2] = 1'b1;
        repeat (5) tick_cycle();
        hit_async[2] = 1'b0;
        read_pix(2, 1'b0, 0, 3'd0, "R6");
        // R7: untouched pixel
        read_pix(3, 1'b0, 0, 3'd0, "R7");
        for (int p = 0; p < NPIX; p++) begin
            if (first_m[p] >= 0) begin
                // R4 (pixel 9 also covers R5: second pulse at cycle 30 ignored)
                read_pix(p, 1'b1, ticks[first_m[p] + 2], fine_of(first_m[p] + 2),
                         (p == 9) ? "R5" : "R4");
            end
        end

        // Frame B: external tick selected (R2, R3)
        clk_sel = 1'b1; ring_tick = 1'b1; ext_tick = 1'b0;
        start_frame();
        read_pix(0, 1'b0, 0, 3'd0, "R2");
        start_frame();
        ticks[0] = 0;
        for (int c = 0; c < 30; c++) begin
            fine_phase = fine_of(c);
            if (c == 20) ext_tick = 1'b1;
            if (c == 10) hit_async[7] = 1'b1;
            if (c == 20) hit_async[8] = 1'b1;
            ticks[c+1] = ticks[c] + ((clk_sel ? ext_tick : ring_tick) ? 1 : 0);
            tick_cycle();
        end
        hit_async[7] = 1'b0;
        hit_async[8] = 1'b0;
        // R3: ring ticks ignored while external selected, state stays at seed
        read_pix(7, 1'b1, ticks[12], fine_of(12), "R3");
        read_pix(8, 1'b1, ticks[22], fine_of(22), "R3");
        check(ticks[22] == 2, "R3", ticks[22], 2);

        // R10: capture strobe on the same edge as frame_start
        ext_tick = 1'b0;
        repeat (4) tick_cycle();
        hit_async[4] = 1'b1;
        tick_cycle();
        tick_cycle();
        start_frame();
        repeat (6) tick_cycle();
        read_pix(4, 1'b0, 0, 3'd0, "R10");
        hit_async[4] = 1'b0;

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule